// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control for an 8-bit successive-approximation converter. It owns a four-way analog input selector, a trial code for an external DAC and a single comparator bit that comes back. For each conversion it first spends one cycle sampling the selected input. It then resolves the code one bit per clock, starting from the most significant bit, and finally stores the code in a result register.

Around the search sits a channel sequencer with three modes. Single mode converts one chosen channel once. Dual mode alternates between two chosen channels for as long as it is allowed to run. Step mode converts one channel of the chosen pair for each start event. A conversion run starts either directly from a command write or from a timer overflow pulse once the block has been armed. A completion flag drives the interrupt output, and software clears it by writing zero.

Software reaches the block through one address, a write strobe and a combinational read port. Address 0 holds the configuration: bits 1:0 are the mode (00 single, 01 dual, 10 step, 11 behaves as single), bit 2 selects the timer as the start source, bits 4:3 are channel A and bits 6:5 are channel B. Address 1 is the status: bit 0 is done, bit 1 is busy and bit 2 is armed. Address 2 takes commands: bit 0 is start and bit 1 is stop. Addresses 4 to 7 hold the result registers 0 to 3.

Top module: `sar_sequencer`

## Requirements
- R1: A conversion sets the trial code to 0x80 in the cycle after its sample cycle and resolves one bit per clock from the MSB down. A trial bit is kept when the comparator reports input >= code. The final code lands in a result register on the 9th clock edge after the start edge, which is one sample cycle plus eight compare cycles.
- R2: The selector output names exactly one channel and stays unchanged for the whole of a conversion's compare cycles.
- R3: In single mode (mode 00 or 11) one conversion runs on channel A and its code goes to the result register numbered by channel A (address 4 + channel A). The block then returns to idle.
- R4: In dual mode (mode 01) channel A and channel B are converted alternately, A to result register 0 (address 4) and B to result register 1 (address 5). Pairs repeat until a stop, and done sets at the end of each pair, 18 edges after the start edge for the first pair.
- R5: With config bit 2 clear, a command write with bit 0 set starts at once. With config bit 2 set, that write only arms the block, and each one-cycle trig_in pulse while armed and idle launches a run. In single mode the block disarms when that conversion completes.
- R6: In step mode (mode 10) each start event converts one channel and returns to idle. Events alternate between channel A into result register 0 and channel B into result register 1, beginning with channel A.
- R7: The done flag (status bit 0) and irq set when a single or step conversion, or a dual pair, completes. A status write with bit 0 clear clears the flag, and a completion in the same cycle as that write leaves the flag set.
- R8: A start command issued while a conversion is busy is ignored. It neither restarts nor queues another conversion.
- R9: After reset all result registers read 0x00, status reads 0 and irq is low.
- R10: A command write with bit 1 set aborts any conversion, returns the block to idle and clears the armed state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for writes and reads |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| mux_sel | output | 2 | Analog input selector |
| dac_code | output | 8 | Trial code for the DAC |
| cmp_in | input | 1 | Comparator result, 1 when input >= DAC code |
| trig_in | input | 1 | Timer overflow pulse |
| irq | output | 1 | Completion interrupt, equal to the done flag |

## Verification
The two functions that can fall in the same cycle are the completion that sets done and the software write that clears it. The bench runs a dual pair and counts edges from the start write so that a status write of zero lands on the 18th edge, the same edge on which the pair completes. It then expects the flag still to be set, and expects a later clear write, with no completion beside it, to drop the flag. A second collision places a start command in the middle of a busy conversion. The bench judges that one by checking that busy drops on the 9th edge and stays low afterwards.

// File: rtl/sar_sequencer.sv
module sar_sequencer #(
  parameter int RES = 8,
  parameter int NCH = 4,
  localparam int CW = $clog2(NCH),
  localparam int BW = $clog2(RES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [2:0]     addr,
  input  logic [RES-1:0] wdata,
  output logic [RES-1:0] rdata,
  output logic [CW-1:0]  mux_sel,
  output logic [RES-1:0] dac_code,
  input  logic           cmp_in,
  input  logic           trig_in,
  output logic           irq
);

  localparam logic [1:0] S_IDLE = 2'd0, S_SAMP = 2'd1, S_BITS = 2'd2;
  localparam logic [1:0] M_DUAL = 2'b01, M_STEP = 2'b10;
  localparam logic [RES-1:0] MSB_TRIAL = {1'b1, {(RES-1){1'b0}}};

  logic [1:0]     state;
  logic [RES-1:0] cfg_q, sar, sar_nx;
  logic [RES-1:0] res_q [NCH];
  logic [BW-1:0]  bit_q;
  logic [1:0]     run_mode;
  logic [CW-1:0]  mux_q, widx;
  logic           slot_q, step_q, armed_q, done_q;

  wire [CW-1:0] ch_a    = cfg_q[CW+2:3];
  wire [CW-1:0] ch_b    = cfg_q[2*CW+2:CW+3];
  wire          tsrc    = cfg_q[2];
  wire          cmd_wr  = wr_en && addr == 3'd2;
  wire          start_wr = cmd_wr && wdata[0];
  wire          stop_wr = cmd_wr && wdata[1];
  wire          clr_wr  = wr_en && addr == 3'd1 && !wdata[0];
  wire          busy    = state != S_IDLE;
  wire          is_dual = run_mode == M_DUAL;
  wire          is_step = run_mode == M_STEP;
  wire          last    = state == S_BITS && bit_q == '0;
  wire          finish  = last && !stop_wr && !(is_dual && !slot_q);
  wire          launch  = !busy && !stop_wr && (tsrc ? (armed_q && trig_in) : start_wr);
  wire          l_slot  = (cfg_q[1:0] == M_STEP) ? step_q : 1'b0;

  assign mux_sel  = mux_q;
  assign dac_code = sar;
  assign irq      = done_q;

  always_comb begin
    sar_nx = sar;
    sar_nx[bit_q] = cmp_in;
    if (bit_q != '0) sar_nx[bit_q-1'b1] = 1'b1;
  end

  always_comb widx = (is_dual || is_step) ? CW'(slot_q) : mux_q;

  always_comb begin
    rdata = '0;
    if (addr[2]) rdata = res_q[addr[CW-1:0]];
    else if (addr == 3'd0) rdata = cfg_q;
    else if (addr == 3'd1) rdata = RES'({armed_q, busy, done_q});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cfg_q    <= '0;
      sar      <= '0;
      bit_q    <= '0;
      run_mode <= '0;
      mux_q    <= '0;
      slot_q   <= 1'b0;
      step_q   <= 1'b0;
      armed_q  <= 1'b0;
      done_q   <= 1'b0;
      for (int i = 0; i < NCH; i++) res_q[i] <= '0;
    end else begin
      if (wr_en && addr == 3'd0) cfg_q <= wdata;

      if (finish) done_q <= 1'b1;
      else if (clr_wr) done_q <= 1'b0;

      if (stop_wr) begin
        state   <= S_IDLE;
        armed_q <= 1'b0;
        step_q  <= 1'b0;
      end else begin
        if (start_wr && tsrc && !busy) armed_q <= 1'b1;
        case (state)
          S_IDLE: if (launch) begin
            state    <= S_SAMP;
            run_mode <= cfg_q[1:0];
            slot_q   <= l_slot;
            mux_q    <= l_slot ? ch_b : ch_a;
          end
          S_SAMP: begin
            sar   <= MSB_TRIAL;
            bit_q <= BW'(RES-1);
            state <= S_BITS;
          end
          default: begin
            sar <= sar_nx;
            if (bit_q != '0) bit_q <= bit_q - 1'b1;
            else begin
              res_q[widx] <= sar_nx;
              if (is_dual) begin
                state  <= S_SAMP;
                slot_q <= !slot_q;
                mux_q  <= slot_q ? ch_a : ch_b;
              end else begin
                state <= S_IDLE;
                if (is_step) step_q <= !step_q;
                else armed_q <= 1'b0;
              end
            end
          end
        endcase
      end
    end
  end

  a_r1_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SAMP && !stop_wr) |=> (dac_code == MSB_TRIAL && state == S_BITS));

  a_r2_sel_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BITS) |-> $stable(mux_sel));

  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> irq);

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && clr_wr && !finish) |=> !irq);

  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_wr && !stop_wr && !finish) |=> ($stable(armed_q) && state != S_IDLE));

  a_r10_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_wr |=> (state == S_IDLE && !armed_q));

endmodule

// File: tb/tb_sar_sequencer.sv
module tb_sar_sequencer;
  localparam int CLK_P = 10;

  logic       clk = 0, rst_n = 0, wr_en = 0, trig_in = 0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, dac_code;
  logic [1:0] mux_sel;
  logic       irq, cmp_in;
  logic [7:0] ana [4];
  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;
  assign cmp_in = ana[mux_sel] >= dac_code;

  sar_sequencer dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .mux_sel(mux_sel), .dac_code(dac_code), .cmp_in(cmp_in),
    .trig_in(trig_in), .irq(irq));

  // {channel, code}
  localparam logic [9:0] VEC [6] = '{
    {2'd0, 8'h00}, {2'd1, 8'hFF}, {2'd2, 8'h80},
    {2'd3, 8'h7F}, {2'd0, 8'h55}, {2'd2, 8'hAA}};

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig_in = 1;
    @(negedge clk); trig_in = 0;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    for (int i = 0; i < 4; i++) ana[i] = 8'h00;
    waitn(3);
    rst_n = 1;
    waitn(1);

    // R9 reset state
    for (int i = 0; i < 4; i++) begin
      rd(3'(4 + i), v); chk("R9 result zero", v, 0);
    end
    rd(3'd1, v); chk("R9 status idle", v, 0);
    chk("R9 irq low", irq, 0);

    // R1 R3 single conversions from table
    foreach (VEC[k]) begin
      ana[VEC[k][9:8]] = VEC[k][7:0];
      wr(3'd0, {3'b000, VEC[k][9:8], 3'b000});
      wr(3'd2, 8'h01);
      waitn(8);
      rd(3'd1, v); chk("R1 busy before 9th edge", v[1:0], 2'b10);
      waitn(1);
      rd(3'd1, v); chk("R1 done on 9th edge", v[1:0], 2'b01);
      rd(3'(4 + VEC[k][9:8]), v); chk("R3 result in channel slot", v, VEC[k][7:0]);
      wr(3'd1, 8'h00);
      chk("R7 clear", irq, 0);
    end

    // R8 start ignored while busy
    ana[1] = 8'h40;
    wr(3'd0, 8'b000_01_000);
    wr(3'd2, 8'h01);
    waitn(3);
    wr(3'd2, 8'h01);
    waitn(3);
    rd(3'd1, v); chk("R8 still busy", v[1], 1);
    waitn(1);
    rd(3'd1, v); chk("R8 done on schedule", v[1:0], 2'b01);
    waitn(4);
    rd(3'd1, v); chk("R8 no queued restart", v[1], 0);
    rd(3'd5, v); chk("R8 result", v, 8'h40);
    wr(3'd1, 8'h00);

    // R4 R7 dual mode with a clear colliding with completion
    ana[2] = 8'h3C; ana[1] = 8'hC3;
    wr(3'd0, 8'b0_01_10_0_01);
    wr(3'd2, 8'h01);
    waitn(16);
    wr(3'd1, 8'h00);
    chk("R7 set wins over clear", irq, 1);
    rd(3'd4, v); chk("R4 chan A to reg0", v, 8'h3C);
    rd(3'd5, v); chk("R4 chan B to reg1", v, 8'hC3);
    wr(3'd1, 8'h00);
    chk("R7 plain clear", irq, 0);
    ana[2] = 8'h11; ana[1] = 8'h22;
    for (int i = 0; i < 40 && !irq; i++) @(negedge clk);
    rd(3'd4, v); chk("R4 continuous reg0", v, 8'h11);
    rd(3'd5, v); chk("R4 continuous reg1", v, 8'h22);
    rd(3'd1, v); chk("R4 still running", v[1], 1);
    wr(3'd2, 8'h02);
    rd(3'd1, v); chk("R10 stop idles", v[2:1], 2'b00);
    waitn(20);
    rd(3'd1, v); chk("R10 stays idle", v[1], 0);
    wr(3'd1, 8'h00);

    // R6 step mode
    ana[3] = 8'h9A; ana[0] = 8'h01;
    wr(3'd0, 8'b0_00_11_0_10);
    wr(3'd2, 8'h01);
    waitn(9);
    rd(3'd4, v); chk("R6 first step chan A", v, 8'h9A);
    rd(3'd1, v); chk("R6 idle after step", v[1:0], 2'b01);
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h01);
    waitn(9);
    rd(3'd5, v); chk("R6 second step chan B", v, 8'h01);
    chk("R6 done", irq, 1);
    wr(3'd1, 8'h00);

    // R5 timer-triggered single
    ana[2] = 8'hE7;
    wr(3'd0, 8'b0_00_10_1_00);
    wr(3'd2, 8'h01);
    waitn(3);
    rd(3'd1, v); chk("R5 armed not busy", v[2:0], 3'b100);
    pulse_trig();
    waitn(9);
    rd(3'd6, v); chk("R5 triggered result", v, 8'hE7);
    rd(3'd1, v); chk("R5 disarmed after single", v[2:0], 3'b001);
    wr(3'd1, 8'h00);
    pulse_trig();
    rd(3'd1, v); chk("R5 trigger ignored unarmed", v[1], 0);

    // R10 stop mid conversion; R2 selector held
    wr(3'd0, 8'b0_00_01_0_00);
    wr(3'd2, 8'h01);
    waitn(3);
    v = {6'd0, mux_sel};
    waitn(3);
    chk("R2 selector held", mux_sel, v[1:0]);
    wr(3'd2, 8'h02);
    rd(3'd1, v); chk("R10 abort", v[2:0], 3'b000);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule